// File: doc/BRIEF.md
# Repeat-Mode DMA Address and Count Sequencer

This block is the address and count engine of one DMA channel that works in repeat mode. Software programs two start addresses, a data unit size, a byte budget, a block length in units, the side of the transfer that should wrap, and a few control bits. Each request the channel accepts produces exactly one transfer descriptor on a valid/ready port. The descriptor holds a source address, a destination address and the unit size. A downstream bus engine performs the actual read and write.

After each descriptor is taken, the addresses and counters advance. The wrapping side returns to its start address at the end of every block. The byte budget shrinks by one unit per transfer, and a zero budget means the channel runs without limit. The channel can also be told to halt at a block boundary. In that case the first request after a finished block is swallowed: the channel turns itself off and raises an end flag, which can drive the interrupt line.

Configuration is a write-only register port. The register index is `cfgAddr`:
- 0: source start
- 1: destination start
- 2: byte budget
- 3: block length (the low RW bits)
- 4: control, with these bits:
  - [0] enable
  - [2:1] size code
  - [4:3] repeat side
  - [5] stop at block end
  - [6] end interrupt enable
- 5: status clear, where writing 1 to bit 0 clears the end flag and writing 1 to bit 1 clears the done flag.

Writing the control register with enable at 1 while the channel is off loads the working addresses and counters from the programmed values.

Top module: `dma_repeat_seq`

## Requirements
- R1: After reset, chEnable, descValid, reqReady, endFlag, doneFlag and irq are all 0.
- R2: reqReady is 1 only while the channel is enabled and no descriptor is outstanding. Each accepted request that is not a block-end stop produces exactly one descriptor on the next cycle. A request is ignored while the channel is disabled.
- R3: descSize reports the size code (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes; code 3 behaves as 2). Each address that is not wrapping grows by that many bytes per completed descriptor handshake.
- R4: Repeat-side code 1 selects the source and code 2 selects the destination. Codes 0 and 3 select neither. After every L completed transfers, the selected side restarts at its start address.
- R5: A block length field of 0 means L = 2^RW units; any other value v means L = v.
- R6: With a nonzero budget, each transfer consumes one unit of bytes. The handshake that exhausts the budget clears chEnable and sets doneFlag.
- R7: A zero budget makes the channel run without limit. It keeps accepting requests until software writes enable 0, and doneFlag stays 0.
- R8: With stop-at-block-end set, the first request accepted after a completed block issues no descriptor. It clears chEnable and sets endFlag.
- R9: irq equals endFlag AND the end interrupt enable.
- R10: Each flag stays set until software writes 1 to its bit in the status-clear register.
- R11: While descValid is 1 and descReady is 0, the descriptor addresses hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register index |
| cfgWdata | input | 32 | Configuration write data |
| reqValid | input | 1 | Transfer request |
| reqReady | output | 1 | Request can be accepted |
| descValid | output | 1 | Descriptor is presented |
| descReady | input | 1 | Descriptor is taken |
| descSrc | output | AW | Source address of the descriptor |
| descDst | output | AW | Destination address of the descriptor |
| descSize | output | 2 | Size code of the descriptor |
| chEnable | output | 1 | Channel enable state |
| endFlag | output | 1 | Block-end stop flag |
| doneFlag | output | 1 | Budget exhausted flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with RW = 3, so block lengths 1 through 8 exist. This includes the zero field that encodes the full 2^RW length, and it lets a short run cross several block boundaries. The sweep covers every size code, every repeat-side code and every length field. The expected source and destination of every descriptor follow from the transfer index modulo the block length. Further runs use the zero budget and the stop-at-block-end option, which brings the end flag, the interrupt and the flag clearing into reach.

// File: rtl/dmarpt_pkg.sv
package dmarpt_pkg;
  localparam logic [2:0] CFG_SRC  = 3'd0;
  localparam logic [2:0] CFG_DST  = 3'd1;
  localparam logic [2:0] CFG_TOT  = 3'd2;
  localparam logic [2:0] CFG_LEN  = 3'd3;
  localparam logic [2:0] CFG_CTRL = 3'd4;
  localparam logic [2:0] CFG_STAT = 3'd5;

  localparam logic [1:0] SIDE_SRC = 2'd1;
  localparam logic [1:0] SIDE_DST = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic load;  // copy programmed values into working registers
    logic step;  // advance after a descriptor handshake
  } dp_strobe_t;

  function automatic logic [2:0] unitBytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dmarpt_datapath.sv
module dmarpt_datapath
  import dmarpt_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [2:0]    cfgAddr,
  input  logic [31:0]   cfgWdata,
  input  dp_strobe_t    strobe,
  input  logic [1:0]    sizeCode,
  input  logic [1:0]    side,
  output logic [AW-1:0] srcAddr,
  output logic [AW-1:0] dstAddr,
  output logic          repLast,
  output logic          totLast
);
  localparam int RCW = RW + 1;

  logic [AW-1:0]  srcStartQ, dstStartQ, srcQ, dstQ;
  logic [CW-1:0]  totCfgQ, totQ;
  logic [RW-1:0]  lenCfgQ;
  logic [RCW-1:0] repQ, lenUnits;
  logic           freeRunQ;
  logic [2:0]     unit;

  assign unit     = unitBytes(sizeCode);
  assign lenUnits = (lenCfgQ == '0) ? {1'b1, {RW{1'b0}}} : {1'b0, lenCfgQ};
  assign repLast  = (repQ == RCW'(1));
  assign totLast  = !freeRunQ && (totQ <= CW'(unit));
  assign srcAddr  = srcQ;
  assign dstAddr  = dstQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcStartQ <= '0;
      dstStartQ <= '0;
      totCfgQ   <= '0;
      lenCfgQ   <= '0;
    end else if (cfgWe) begin
      case (cfgAddr)
        CFG_SRC: srcStartQ <= AW'(cfgWdata);
        CFG_DST: dstStartQ <= AW'(cfgWdata);
        CFG_TOT: totCfgQ   <= CW'(cfgWdata);
        CFG_LEN: lenCfgQ   <= cfgWdata[RW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ     <= '0;
      dstQ     <= '0;
      totQ     <= '0;
      repQ     <= '0;
      freeRunQ <= 1'b0;
    end else if (strobe.load) begin
      srcQ     <= srcStartQ;
      dstQ     <= dstStartQ;
      totQ     <= totCfgQ;
      repQ     <= lenUnits;
      freeRunQ <= (totCfgQ == '0);
    end else if (strobe.step) begin
      srcQ <= (side == SIDE_SRC && repLast) ? srcStartQ : srcQ + AW'(unit);
      dstQ <= (side == SIDE_DST && repLast) ? dstStartQ : dstQ + AW'(unit);
      repQ <= repLast ? lenUnits : repQ - RCW'(1);
      if (!freeRunQ) totQ <= totQ - CW'(unit);
    end
  end
endmodule

// File: rtl/dmarpt_control.sv
module dmarpt_control
  import dmarpt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [2:0]  cfgAddr,
  input  logic [31:0] cfgWdata,
  input  logic        reqValid,
  input  logic        descReady,
  input  logic        repLast,
  input  logic        totLast,
  output dp_strobe_t  strobe,
  output logic        reqReady,
  output logic        descValid,
  output logic        chEnable,
  output logic        endFlag,
  output logic        doneFlag,
  output logic        irq,
  output logic [1:0]  sizeCode,
  output logic [1:0]  side
);
  logic       enQ, busyQ, blockDoneQ, endFlagQ, doneFlagQ, stopIeQ, endIeQ;
  logic [1:0] sizeQ, sideQ;
  logic       ctrlWr, statWr, accept, stopNow, handshake;

  assign ctrlWr    = cfgWe && (cfgAddr == CFG_CTRL);
  assign statWr    = cfgWe && (cfgAddr == CFG_STAT);
  assign reqReady  = enQ && !busyQ;
  assign accept    = reqValid && reqReady;
  assign stopNow   = accept && blockDoneQ && stopIeQ;
  assign handshake = busyQ && descReady;

  assign strobe.load = ctrlWr && cfgWdata[0] && !enQ;
  assign strobe.step = handshake;

  assign descValid = busyQ;
  assign chEnable  = enQ;
  assign endFlag   = endFlagQ;
  assign doneFlag  = doneFlagQ;
  assign irq       = endFlagQ && endIeQ;
  assign sizeCode  = (sizeQ == 2'd3) ? 2'd2 : sizeQ;
  assign side      = sideQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ        <= 1'b0;
      busyQ      <= 1'b0;
      blockDoneQ <= 1'b0;
      endFlagQ   <= 1'b0;
      doneFlagQ  <= 1'b0;
      stopIeQ    <= 1'b0;
      endIeQ     <= 1'b0;
      sizeQ      <= 2'd0;
      sideQ      <= 2'd0;
    end else begin
      if (stopNow || (handshake && totLast)) enQ <= 1'b0;
      if (ctrlWr) begin
        enQ     <= cfgWdata[0];
        sizeQ   <= cfgWdata[2:1];
        sideQ   <= cfgWdata[4:3];
        stopIeQ <= cfgWdata[5];
        endIeQ  <= cfgWdata[6];
      end

      if (accept && !stopNow) busyQ <= 1'b1;
      else if (handshake)     busyQ <= 1'b0;

      if (strobe.load || accept)    blockDoneQ <= 1'b0;
      else if (handshake && repLast) blockDoneQ <= 1'b1;

      if (stopNow)                      endFlagQ <= 1'b1;
      else if (statWr && cfgWdata[0])   endFlagQ <= 1'b0;

      if (handshake && totLast)         doneFlagQ <= 1'b1;
      else if (statWr && cfgWdata[1])   doneFlagQ <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_repeat_seq.sv
module dma_repeat_seq
  import dmarpt_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [2:0]    cfgAddr,
  input  logic [31:0]   cfgWdata,
  input  logic          reqValid,
  output logic          reqReady,
  output logic          descValid,
  input  logic          descReady,
  output logic [AW-1:0] descSrc,
  output logic [AW-1:0] descDst,
  output logic [1:0]    descSize,
  output logic          chEnable,
  output logic          endFlag,
  output logic          doneFlag,
  output logic          irq
);
  dp_strobe_t strobe;
  logic       repLast, totLast;
  logic [1:0] side;

  dmarpt_control u_ctl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .reqValid(reqValid), .descReady(descReady), .repLast(repLast), .totLast(totLast),
    .strobe(strobe), .reqReady(reqReady), .descValid(descValid), .chEnable(chEnable),
    .endFlag(endFlag), .doneFlag(doneFlag), .irq(irq), .sizeCode(descSize), .side(side)
  );

  dmarpt_datapath #(.AW(AW), .CW(CW), .RW(RW)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .strobe(strobe), .sizeCode(descSize), .side(side),
    .srcAddr(descSrc), .dstAddr(descDst), .repLast(repLast), .totLast(totLast)
  );
endmodule

// File: rtl/dma_repeat_seq_chk.sv
module dma_repeat_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          reqReady,
  input logic          descValid,
  input logic          descReady,
  input logic [AW-1:0] descSrc,
  input logic [AW-1:0] descDst,
  input logic [1:0]    descSize,
  input logic          chEnable,
  input logic          endFlag,
  input logic          doneFlag,
  input logic          irq
);
  AST_DESC_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(descValid) |-> $past(reqValid && reqReady)); // R2
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    descValid |-> descSize != 2'd3); // R3
  AST_DONE_DISABLES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> !chEnable); // R6
  AST_STOP_NO_DESC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(endFlag) |-> !descValid && !chEnable); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> endFlag); // R9
  AST_DESC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    descValid && !descReady |=> descValid && $stable(descSrc) && $stable(descDst)); // R11
endmodule

bind dma_repeat_seq dma_repeat_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/dma_repeat_seq_tb.sv
module dma_repeat_seq_tb;
  localparam int AW = 32;
  localparam int RW = 3;
  localparam logic [31:0] SRC0 = 32'h1000;
  localparam logic [31:0] DST0 = 32'h8000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [2:0] cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic reqValid = 1'b0;
  logic descReady = 1'b0;
  logic reqReady, descValid, chEnable, endFlag, doneFlag, irq;
  logic [AW-1:0] descSrc, descDst;
  logic [1:0] descSize;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dma_repeat_seq #(.AW(AW), .CW(32), .RW(RW)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .reqValid(reqValid), .reqReady(reqReady), .descValid(descValid), .descReady(descReady),
    .descSrc(descSrc), .descDst(descDst), .descSize(descSize), .chEnable(chEnable),
    .endFlag(endFlag), .doneFlag(doneFlag), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] a, input logic [31:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // one request and one descriptor handshake; k is the transfer index
  task automatic doXfer(input int k, input int ub, input int sideC, input int L,
                        input int szExp, input bit stall);
    longint p, sExp, dExp;
    chk(reqReady == 1'b1, "R2 ready", reqReady, 1);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    p = k % L;
    sExp = SRC0 + ((sideC == 1) ? p : k) * ub;
    dExp = DST0 + ((sideC == 2) ? p : k) * ub;
    chk(descValid == 1'b1, "R2 desc", descValid, 1);
    chk(descSrc == sExp[31:0], "R4 src", descSrc, sExp);
    chk(descDst == dExp[31:0], "R3 dst", descDst, dExp);
    chk(descSize == szExp[1:0], "R3 size", descSize, szExp);
    if (stall) begin
      @(negedge clk);
      chk(descValid && descSrc == sExp[31:0] && descDst == dExp[31:0], "R11 hold",
          descSrc, sExp);
    end
    descReady = 1'b1;
    @(negedge clk);
    descReady = 1'b0;
  endtask

  task automatic startRun(input int sz, input int sideC, input int lenF, input longint tot,
                          input bit stopIe);
    cfgWrite(3'd4, 32'h0);
    cfgWrite(3'd5, 32'h3);
    cfgWrite(3'd0, SRC0);
    cfgWrite(3'd1, DST0);
    cfgWrite(3'd2, tot[31:0]);
    cfgWrite(3'd3, 32'(lenF));
    cfgWrite(3'd4, {25'd0, 1'b1, stopIe, sideC[1:0], sz[1:0], 1'b1});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({chEnable, descValid, reqReady, endFlag, doneFlag, irq} == 6'b0, "R1 reset",
        {chEnable, descValid, reqReady, endFlag, doneFlag, irq}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 request ignored while disabled
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    chk(descValid == 1'b0 && reqReady == 1'b0, "R2 disabled", descValid, 0);

    // R3 R4 R5 R6 sweep with a finite budget
    for (int sz = 0; sz < 4; sz++)
      for (int sd = 0; sd < 4; sd++)
        for (int lf = 0; lf < 8; lf++) begin
          int ub, L, szE, n;
          ub  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
          szE = (sz == 3) ? 2 : sz;
          L   = (lf == 0) ? 8 : lf;
          n   = 10;
          startRun(sz, sd, lf, n * ub, 1'b0);
          for (int k = 0; k < n; k++) begin
            doXfer(k, ub, sd, L, szE, k == 1);
            if (k < n - 1)
              chk(chEnable == 1'b1 && doneFlag == 1'b0, "R6 running", chEnable, 1);
          end
          chk(chEnable == 1'b0 && doneFlag == 1'b1, "R6 done", {chEnable, doneFlag}, 1);
          chk(irq == 1'b0, "R9 no irq on done", irq, 0);
        end

    // R10 done flag stays until cleared
    @(negedge clk);
    chk(doneFlag == 1'b1, "R10 done sticky", doneFlag, 1);
    cfgWrite(3'd5, 32'h2);
    chk(doneFlag == 1'b0, "R10 done clear", doneFlag, 0);

    // R7 free-running across all sides
    for (int sd = 0; sd < 4; sd++) begin
      startRun(1, sd, 3, 0, 1'b0);
      for (int k = 0; k < 20; k++) doXfer(k, 2, sd, 3, 1, 1'b0);
      chk(chEnable == 1'b1 && doneFlag == 1'b0, "R7 still running", chEnable, 1);
      cfgWrite(3'd4, 32'h0);
      chk(reqReady == 1'b0 && chEnable == 1'b0, "R7 software stop", reqReady, 0);
    end

    // R8 R9 R10 stop at block end, every length
    for (int lf = 0; lf < 8; lf++) begin
      int L;
      L = (lf == 0) ? 8 : lf;
      startRun(2, 1, lf, 0, 1'b1);
      for (int k = 0; k < L; k++) doXfer(k, 4, 1, L, 2, 1'b0);
      chk(chEnable == 1'b1 && endFlag == 1'b0, "R8 before stop", chEnable, 1);
      reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      chk(descValid == 1'b0, "R8 no desc", descValid, 0);
      chk(chEnable == 1'b0 && endFlag == 1'b1, "R8 stopped", {chEnable, endFlag}, 1);
      chk(irq == 1'b1, "R9 irq", irq, 1);
      @(negedge clk);
      chk(endFlag == 1'b1, "R10 end sticky", endFlag, 1);
      cfgWrite(3'd5, 32'h1);
      chk(endFlag == 1'b0 && irq == 1'b0, "R10 end clear", endFlag, 0);
    end

    // R9 end flag without interrupt enable
    cfgWrite(3'd4, 32'h0);
    cfgWrite(3'd3, 32'd2);
    cfgWrite(3'd2, 32'd0);
    cfgWrite(3'd4, 32'h21);
    doXfer(0, 1, 0, 2, 0, 1'b0);
    doXfer(1, 1, 0, 2, 0, 1'b0);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(endFlag == 1'b1 && irq == 1'b0, "R9 masked", {endFlag, irq}, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule